// File: doc/BRIEF.md
# Video Line and Frame Sequencer

This block derives raster timing from the system clock. A cycle counter divides the clock into line periods and emits a one-cycle horizontal strobe at the start of each line. A line counter steps on each strobe and wraps at the frame total. The frame total is 263 lines for the 60 Hz standard and 314 lines for the 50 Hz standard. The block raises a vertical-blank level and a one-cycle vertical-blank interrupt at a fixed line. At each wrap it advances a frame counter and produces an odd/even field flag for interlaced output.

The line period is computed at elaboration as the clock rate divided by the product of frame rate and lines per frame. That gives about 2146 cycles at 60 Hz and 2157 cycles at 50 Hz for a 33.8688 MHz clock. The standard select is sampled while reset is held and again at each frame wrap. A frame therefore never mixes two standards. The block does timing only; pixel data and display memory belong elsewhere.

Top module: `vts_seq`

## Requirements
- R1: While reset is held and in the first cycle after it, line_o is 0 and hsync_o, vblank_o, vblank_irq_o and field_o are all 0.
- R2: hsync_o is high for exactly one cycle every P cycles. P is CLK_HZ/(60*263) when the active standard is 0 (60 Hz) and CLK_HZ/(50*314) when it is 1 (50 Hz), using integer division. The first strobe comes P cycles after reset is released.
- R3: line_o changes only in a cycle where hsync_o is high, and it then takes the previous value plus one, except at the frame wrap.
- R4: A frame holds 263 lines under standard 0 and 314 lines under standard 1. The strobe that follows the last line sets line_o back to 0.
- R5: vblank_o rises in the cycle where line_o becomes 240, stays high, and falls in the cycle where line_o wraps to 0.
- R6: vblank_irq_o is high for exactly one cycle per frame, in the cycle where line_o becomes 240.
- R7: At each wrap a frame counter increments. field_o then takes the counter's LSB when interlace_i is 1, or 0 when interlace_i is 0. field_o holds between wraps.
- R8: std_sel_i is sampled only during reset and at a frame wrap. A change in mid-frame alters neither the line period nor the line total of the current frame.
- R9: A change of interlace_i in mid-frame leaves field_o unchanged until the next wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| std_sel_i | input | 1 | Standard select: 0 = 60 Hz/263 lines, 1 = 50 Hz/314 lines |
| interlace_i | input | 1 | Interlace enable for the field flag |
| hsync_o | output | 1 | One-cycle strobe at the start of each line |
| vblank_o | output | 1 | Vertical-blank level |
| vblank_irq_o | output | 1 | One-cycle vertical-blank interrupt pulse |
| line_o | output | LINE_W (9) | Current line number |
| field_o | output | 1 | Odd/even field flag |

## Verification
Every output is registered, so each result is due one clock edge after the cycle that causes it. The strobe, the new line number, the blank edge and the interrupt all appear together in the cycle after the counter reaches P-1. The field flag and the newly latched standard appear in the cycle after the wrap. The bench model advances on the same rising edge as the design, taking the inputs that were driven on the previous falling edge. It compares all five outputs on every falling edge, so each expected value is checked exactly in the cycle it falls due. Targeted checks measure strobe spacing and line totals by counting falling edges between strobes. They also change the standard and interlace inputs in mid-frame to confirm that neither takes effect before the wrap.

// File: rtl/vts_pkg.sv
package vts_pkg;

    typedef enum logic {
        STD_60 = 1'b0,
        STD_50 = 1'b1
    } vstd_e;

    typedef struct packed {
        logic vblank;
        logic irq;
        logic field;
    } vstat_t;

    function automatic int unsigned line_period(input longint unsigned clk_hz,
                                                input int unsigned rate,
                                                input int unsigned lines);
        longint unsigned q;
        q = clk_hz / (longint'(rate) * longint'(lines));
        return int'(q);
    endfunction

    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/vts_line_timer.sv
module vts_line_timer
    import vts_pkg::*;
#(
    parameter int unsigned PER_A = 2146,
    parameter int unsigned PER_B = 2157,
    parameter int unsigned CNT_W = 12
) (
    input  logic  clk,
    input  logic  rst,
    input  vstd_e std_q,
    output logic  line_end,
    output logic  hsync_o
);
    localparam logic [CNT_W-1:0] LAST_A = CNT_W'(PER_A - 1);
    localparam logic [CNT_W-1:0] LAST_B = CNT_W'(PER_B - 1);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] last;

    always_comb begin
        last     = (std_q == STD_50) ? LAST_B : LAST_A;
        line_end = (cnt_q == last);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= '0;
            hsync_o <= 1'b0;
        end else begin
            hsync_o <= line_end;
            if (line_end) cnt_q <= '0;
            else          cnt_q <= cnt_q + 1'b1;
        end
    end

    // R2: strobe is a single cycle wide
    a_r2_hsync_single: assert property (@(posedge clk) disable iff (rst)
        hsync_o |=> !hsync_o);

    // R2: strobe marks the first cycle of a line
    a_r2_hsync_at_zero: assert property (@(posedge clk) disable iff (rst)
        hsync_o |-> (cnt_q == '0));

endmodule

// File: rtl/vts_frame_seq.sv
module vts_frame_seq
    import vts_pkg::*;
#(
    parameter int unsigned LINES_A  = 263,
    parameter int unsigned LINES_B  = 314,
    parameter int unsigned VBL_LINE = 240,
    parameter int unsigned LINE_W   = 9,
    parameter int unsigned FRAME_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              line_end,
    input  logic              hsync_i,
    input  logic              std_sel_i,
    input  logic              interlace_i,
    output vstd_e             std_q,
    output logic [LINE_W-1:0] line_o,
    output vstat_t            stat_o
);
    localparam logic [LINE_W-1:0] LAST_A  = LINE_W'(LINES_A - 1);
    localparam logic [LINE_W-1:0] LAST_B  = LINE_W'(LINES_B - 1);
    localparam logic [LINE_W-1:0] PRE_VBL = LINE_W'(VBL_LINE - 1);

    logic [LINE_W-1:0]  line_q;
    logic [FRAME_W-1:0] frame_q;
    logic [FRAME_W-1:0] frame_nxt;
    vstat_t             stat_q;
    logic               last_line;

    always_comb begin
        last_line = (std_q == STD_50) ? (line_q == LAST_B) : (line_q == LAST_A);
        frame_nxt = frame_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            line_q  <= '0;
            frame_q <= '0;
            stat_q  <= '0;
            std_q   <= vstd_e'(std_sel_i);
        end else begin
            stat_q.irq <= 1'b0;
            if (line_end) begin
                if (last_line) begin
                    line_q       <= '0;
                    frame_q      <= frame_nxt;
                    stat_q.vblank <= 1'b0;
                    stat_q.field <= interlace_i & frame_nxt[0];
                    std_q        <= vstd_e'(std_sel_i);
                end else begin
                    line_q <= line_q + 1'b1;
                    if (line_q == PRE_VBL) begin
                        stat_q.vblank <= 1'b1;
                        stat_q.irq    <= 1'b1;
                    end
                end
            end
        end
    end

    assign line_o = line_q;
    assign stat_o = stat_q;

    // R3: line number moves only with the strobe
    a_r3_line_hold: assert property (@(posedge clk) disable iff (rst)
        !hsync_i |-> $stable(line_q));

    // R3: line number steps by one except at the wrap
    a_r3_line_step: assert property (@(posedge clk) disable iff (rst)
        (hsync_i && line_q != '0) |-> (line_q == $past(line_q) + 1'b1));

    // R5: blank rises at the blank line together with the interrupt
    a_r5_vblank_rise: assert property (@(posedge clk) disable iff (rst)
        $rose(stat_q.vblank) |-> (line_q == LINE_W'(VBL_LINE) && stat_q.irq));

    // R5: blank falls only at the wrap
    a_r5_vblank_fall: assert property (@(posedge clk) disable iff (rst)
        $fell(stat_q.vblank) |-> (line_q == '0));

    // R6: interrupt is a single cycle
    a_r6_irq_single: assert property (@(posedge clk) disable iff (rst)
        stat_q.irq |=> !stat_q.irq);

    // R7 / R9: field changes only at the wrap
    a_r7_field_hold: assert property (@(posedge clk) disable iff (rst)
        !(hsync_i && line_q == '0) |-> $stable(stat_q.field));

endmodule

// File: rtl/vts_seq.sv
module vts_seq
    import vts_pkg::*;
#(
    parameter int unsigned CLK_HZ   = 33868800,
    parameter int unsigned RATE_A   = 60,
    parameter int unsigned LINES_A  = 263,
    parameter int unsigned RATE_B   = 50,
    parameter int unsigned LINES_B  = 314,
    parameter int unsigned VBL_LINE = 240,
    parameter int unsigned FRAME_W  = 16,
    parameter int unsigned LINE_W   = $clog2(max2(LINES_A, LINES_B))
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              std_sel_i,
    input  logic              interlace_i,
    output logic              hsync_o,
    output logic              vblank_o,
    output logic              vblank_irq_o,
    output logic [LINE_W-1:0] line_o,
    output logic              field_o
);
    localparam int unsigned PER_A = line_period(longint'(CLK_HZ), RATE_A, LINES_A);
    localparam int unsigned PER_B = line_period(longint'(CLK_HZ), RATE_B, LINES_B);
    localparam int unsigned CNT_W = $clog2(max2(max2(PER_A, PER_B), 2));

    vstd_e  std_q;
    logic   line_end;
    logic   hsync_w;
    vstat_t stat;

    vts_line_timer #(
        .PER_A (PER_A),
        .PER_B (PER_B),
        .CNT_W (CNT_W)
    ) u_timer (
        .clk      (clk),
        .rst      (rst),
        .std_q    (std_q),
        .line_end (line_end),
        .hsync_o  (hsync_w)
    );

    vts_frame_seq #(
        .LINES_A  (LINES_A),
        .LINES_B  (LINES_B),
        .VBL_LINE (VBL_LINE),
        .LINE_W   (LINE_W),
        .FRAME_W  (FRAME_W)
    ) u_frame (
        .clk         (clk),
        .rst         (rst),
        .line_end    (line_end),
        .hsync_i     (hsync_w),
        .std_sel_i   (std_sel_i),
        .interlace_i (interlace_i),
        .std_q       (std_q),
        .line_o      (line_o),
        .stat_o      (stat)
    );

    assign hsync_o      = hsync_w;
    assign vblank_o     = stat.vblank;
    assign vblank_irq_o = stat.irq;
    assign field_o      = stat.field;

    // R1: outputs quiet in the first cycle after reset
    a_r1_quiet_after_reset: assert property (@(posedge clk)
        $fell(rst) |-> (!hsync_o && !vblank_o && !vblank_irq_o && !field_o && line_o == '0));

endmodule

// File: tb/sim_vts_seq.sv
module sim_vts_seq;
    localparam int CLK_PERIOD = 10;
    localparam int CLK_HZ     = 157000;
    localparam int L60 = 263;
    localparam int L50 = 314;
    localparam int VBL = 240;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       std_sel = 1'b0;
    logic       ilace = 1'b0;
    logic       hsync_o, vblank_o, vblank_irq_o, field_o;
    logic [8:0] line_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    vts_seq #(.CLK_HZ(CLK_HZ)) u0 (
        .clk          (clk),
        .rst          (rst),
        .std_sel_i    (std_sel),
        .interlace_i  (ilace),
        .hsync_o      (hsync_o),
        .vblank_o     (vblank_o),
        .vblank_irq_o (vblank_irq_o),
        .line_o       (line_o),
        .field_o      (field_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic int per_of(bit s);
        return s ? CLK_HZ / (50 * L50) : CLK_HZ / (60 * L60);
    endfunction

    // behavioural reference
    int cnt_m, line_m, frame_m;
    bit std_m, hs_m, vb_m, irq_m, fld_m;

    always @(posedge clk) begin
        if (rst) begin
            cnt_m = 0; line_m = 0; frame_m = 0; std_m = std_sel;
            hs_m = 0; vb_m = 0; irq_m = 0; fld_m = 0;
        end else begin
            hs_m = 0; irq_m = 0;
            if (cnt_m == per_of(std_m) - 1) begin
                cnt_m = 0; hs_m = 1;
                if (line_m == (std_m ? L50 : L60) - 1) begin
                    line_m = 0; vb_m = 0; frame_m++;
                    fld_m = ilace && (frame_m % 2 == 1);
                    std_m = std_sel;
                end else begin
                    line_m++;
                    if (line_m == VBL) begin vb_m = 1; irq_m = 1; end
                end
            end else begin
                cnt_m++;
            end
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (!done) begin
            check(hsync_o == hs_m, "R2 hsync", int'(hsync_o), int'(hs_m));
            check(int'(line_o) == line_m, "R3/R4 line", int'(line_o), line_m);
            check(vblank_o == vb_m, "R5 vblank", int'(vblank_o), int'(vb_m));
            check(vblank_irq_o == irq_m, "R6 irq", int'(vblank_irq_o), int'(irq_m));
            check(field_o == fld_m, "R7/R9 field", int'(field_o), int'(fld_m));
        end
    end

    task automatic wait_hsync();
        do @(negedge clk); while (!hsync_o);
    endtask

    task automatic wait_wrap();
        do @(negedge clk); while (!(hsync_o && line_o == 0));
    endtask

    task automatic wait_line(input int ln);
        do @(negedge clk); while (!(hsync_o && int'(line_o) == ln));
    endtask

    task automatic measure_period(output int n);
        n = 0;
        do begin @(negedge clk); n++; end while (!hsync_o);
    endtask

    task automatic frame_lines(output int n);
        n = 0;
        do begin wait_hsync(); n++; end while (line_o != 0);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_checks++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        finish_run();
    end

    initial begin
        int p, n, gap;
        repeat (4) @(negedge clk);
        check(line_o == 0 && !hsync_o && !vblank_o && !vblank_irq_o && !field_o,
              "R1 reset state", int'(line_o), 0);
        rst = 1'b0;
        // R2: first strobe P cycles after release
        measure_period(n);
        check(n == per_of(0), "R2 first strobe", n, per_of(0));
        check(line_o == 1, "R3 line after first strobe", int'(line_o), 1);
        measure_period(p);
        check(p == per_of(0), "R2 period 60Hz", p, per_of(0));
        // R8: mid-frame standard change has no effect yet
        wait_line(100);
        std_sel = 1'b1;
        measure_period(p);
        check(p == per_of(0), "R8 period unchanged mid-frame", p, per_of(0));
        // R6/R5 at blank line
        wait_line(VBL);
        check(vblank_o && vblank_irq_o, "R6 irq at line 240", int'(vblank_irq_o), 1);
        @(negedge clk);
        check(!vblank_irq_o && vblank_o, "R6 irq single cycle", int'(vblank_irq_o), 0);
        gap = 0;
        wait_wrap();
        check(!vblank_o, "R5 vblank falls at wrap", int'(vblank_o), 0);
        measure_period(p);
        check(p == per_of(1), "R8 new period after wrap", p, per_of(1));
        // R4: 50 Hz frame total
        wait_wrap();
        frame_lines(n);
        check(n == L50, "R4 lines 50Hz", n, L50);
        // R9: interlace and standard changed mid-frame
        wait_line(150);
        ilace = 1'b1;
        std_sel = 1'b0;
        wait_line(L50 - 1);
        check(field_o == 1'b0, "R9 field held mid-frame", int'(field_o), 0);
        wait_wrap();
        @(negedge clk);
        check(field_o == (frame_m % 2 == 1), "R7 field at wrap", int'(field_o), frame_m % 2);
        // R4: 60 Hz frame total after switching back
        frame_lines(n);
        check(n == L60, "R4 lines 60Hz", n, L60);
        @(negedge clk);
        check(field_o == (frame_m % 2 == 1), "R7 field toggles", int'(field_o), frame_m % 2);
        frame_lines(n);
        @(negedge clk);
        check(field_o == (frame_m % 2 == 1), "R7 field toggles again", int'(field_o), frame_m % 2);
        // interlace off: field forced to 0 at next wrap
        wait_line(50);
        ilace = 1'b0;
        wait_wrap();
        @(negedge clk);
        check(field_o == 1'b0, "R7 field 0 when not interlaced", int'(field_o), 0);
        repeat (50) @(negedge clk);
        if (gap != 0) n_fail++;
        finish_run();
    end
endmodule